// File: doc/BRIEF.md
# Multi-Stream SDI Data Interleaver

This block places up to sixteen 10-bit elementary data streams onto a 40-bit transmit word. It sits in front of a serializer on a single clock domain. A 3-bit pattern select picks the arrangement. Some arrangements are fixed. Others alternate on a half-rate lane enable. One rotates through four phases in a fixed, non-sequential order, and that rotation is anchored to a quarter-rate enable pulse. The word is registered, so a new word appears one clock edge after the inputs it was built from.

Alongside the data, the block watches the enable cadence. It raises a sticky error flag when the spacing of the enable pulses does not fit the selected pattern. A synchronous clear input drops the flag. Mapping video formats into elementary streams is done outside this block, as are serialization and scrambling.

Stream n (n = 1..16) enters on `ds_bus[n*LANE_W-1 -: LANE_W]`. In every arrangement below, the first-listed stream occupies the most significant lane of the word.

Top module: `sdi_interleaver`

## Requirements
- R1: A synchronous active-high `rst` clears `tx_word` to zero and `cadence_err` to 0 on the next edge. It also clears the phase tracking and cadence history.
- R2: With pattern 3'b000, `tx_word[19:10]` carries stream 1 and `tx_word[9:0]` carries stream 2. `tx_word[39:20]` is zero.
- R3: With pattern 3'b001, the low 20 bits are {stream 1, stream 3} when `lane_ce` is 1 and {stream 2, stream 4} when it is 0. The upper 20 bits are zero.
- R4: With pattern 3'b010, the word is {ds1, ds5, ds3, ds7} when `lane_ce` is 1 and {ds2, ds6, ds4, ds8} when it is 0.
- R5: With pattern 3'b011, the word is always {ds1, ds3, ds2, ds4}.
- R6: With pattern 3'b100, the edge that samples `lane_ce` high emits {ds4, ds12, ds8, ds16} (phase 0). The following edges emit {ds2, ds10, ds6, ds14} (phase 1), then {ds3, ds11, ds7, ds15} (phase 2), then {ds1, ds9, ds5, ds13} (phase 3).
- R7: Without a new enable, the phase stays at phase 3. Any edge on which the pattern code differs from the previous edge's code starts again at phase 0.
- R8: Pattern codes 3'b101, 3'b110 and 3'b111 give an all-zero word.
- R9: Under patterns 3'b000 and 3'b011, an edge that samples `lane_ce` low sets `cadence_err`.
- R10: Under patterns 3'b001 and 3'b010, an edge that samples the same `lane_ce` value as the previous edge sets `cadence_err`.
- R11: Under pattern 3'b100, once an enable has been seen, `cadence_err` is set in two cases. One is an enable that comes fewer than four edges after the previous one. The other is a fourth consecutive edge without an enable.
- R12: `cadence_err` is sticky and cleared by `err_clr`. A violation in the same cycle as `err_clr` wins. The first edge after reset, and any edge where the pattern changes, is not checked.
- R13: `tx_word` reflects the streams, pattern and enable sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_ce | input | 1 | Cadence enable that marks the arrangement phase |
| pat_sel | input | 3 | Arrangement pattern code |
| ds_bus | input | 16*LANE_W | Sixteen elementary streams, stream n at bits [n*LANE_W-1 -: LANE_W] |
| err_clr | input | 1 | Synchronous clear of the cadence error flag |
| tx_word | output | 4*LANE_W | Registered interleaved transmit word |
| cadence_err | output | 1 | Sticky cadence mismatch flag |

## Verification
The bench builds the block with the default `LANE_W` of 10. This gives a 40-bit word whose lane positions match the documented 10-bit layouts, so every arrangement can be compared lane by lane against a model that draws fresh random stream data each cycle.

The stimulus walks every pattern code, including the undefined ones, and switches patterns in the middle of a rotation. It also drives enable gaps of three, four and more than four edges. These exercise the phase saturation, the restart on a pattern change, and each cadence rule, including a clear that coincides with a violation.

// File: rtl/sdi_interleaver_pkg.sv
`timescale 1ns/1ps
package sdi_interleaver_pkg;
  localparam int NUM_DS = 16;
  localparam int LANES  = 4;
  localparam int IDX_W  = $clog2(NUM_DS + 1);

  typedef logic [2:0]       pat_t;
  typedef logic [1:0]       phase_t;
  typedef logic [IDX_W-1:0] ds_idx_t;
  // entry [LANES-1] is the most significant lane; index 0 means "drive zero"
  typedef logic [LANES-1:0][IDX_W-1:0] lane_map_t;

  localparam pat_t PAT_PAIR_THRU = 3'd0;
  localparam pat_t PAT_PAIR_ALT  = 3'd1;
  localparam pat_t PAT_QUAD_ALT  = 3'd2;
  localparam pat_t PAT_QUAD_FIX  = 3'd3;
  localparam pat_t PAT_QUAD_ROT  = 3'd4;

  localparam phase_t PH_LAST = 2'd3;

  function automatic lane_map_t lane_map(input pat_t p, input logic en, input phase_t ph);
    lane_map_t m;
    ds_idx_t   b;
    m = '0;
    b = '0;
    case (p)
      PAT_PAIR_THRU: begin
        m[1] = ds_idx_t'(1);
        m[0] = ds_idx_t'(2);
      end
      PAT_PAIR_ALT: begin
        b    = en ? ds_idx_t'(1) : ds_idx_t'(2);
        m[1] = b;
        m[0] = b + ds_idx_t'(2);
      end
      PAT_QUAD_ALT: begin
        b    = en ? ds_idx_t'(1) : ds_idx_t'(2);
        m[3] = b;
        m[2] = b + ds_idx_t'(4);
        m[1] = b + ds_idx_t'(2);
        m[0] = b + ds_idx_t'(6);
      end
      PAT_QUAD_FIX: begin
        m[3] = ds_idx_t'(1);
        m[2] = ds_idx_t'(3);
        m[1] = ds_idx_t'(2);
        m[0] = ds_idx_t'(4);
      end
      PAT_QUAD_ROT: begin
        case (ph)
          2'd0:    b = ds_idx_t'(4);
          2'd1:    b = ds_idx_t'(2);
          2'd2:    b = ds_idx_t'(3);
          default: b = ds_idx_t'(1);
        endcase
        m[3] = b;
        m[2] = b + ds_idx_t'(8);
        m[1] = b + ds_idx_t'(4);
        m[0] = b + ds_idx_t'(12);
      end
      default: m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/sdi_lane_mux.sv
`timescale 1ns/1ps
module sdi_lane_mux
  import sdi_interleaver_pkg::*;
#(
  parameter int LANE_W = 10
) (
  input  logic [2:0]               pat_sel,
  input  logic                     lane_ce,
  input  logic [1:0]               phase,
  input  logic [NUM_DS*LANE_W-1:0] ds_bus,
  output logic [LANES*LANE_W-1:0]  word
);
  lane_map_t sel_map;

  always_comb sel_map = lane_map(pat_sel, lane_ce, phase);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] lane_d;
    always_comb begin
      lane_d = '0;
      for (int s = 1; s <= NUM_DS; s++) begin
        if (sel_map[l] == ds_idx_t'(s)) lane_d = ds_bus[(s-1)*LANE_W +: LANE_W];
      end
    end
    assign word[l*LANE_W +: LANE_W] = lane_d;
  end
endmodule

// File: rtl/sdi_phase_tracker.sv
`timescale 1ns/1ps
module sdi_phase_tracker
  import sdi_interleaver_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       lane_ce,
  input  logic [2:0] pat_sel,
  output logic [1:0] cur_phase,
  output logic [1:0] last_phase,
  output logic       pat_chg,
  output logic       hist_vld,
  output logic       ce_prev,
  output logic       seen_ce
);
  pat_t pat_q;

  assign pat_chg   = (pat_sel != pat_q);
  assign cur_phase = (lane_ce || pat_chg) ? 2'd0 :
                     (last_phase == PH_LAST) ? PH_LAST : last_phase + 2'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      pat_q      <= '0;
      last_phase <= '0;
      hist_vld   <= 1'b0;
      ce_prev    <= 1'b0;
      seen_ce    <= 1'b0;
    end else begin
      pat_q      <= pat_sel;
      last_phase <= cur_phase;
      hist_vld   <= 1'b1;
      ce_prev    <= lane_ce;
      seen_ce    <= pat_chg ? lane_ce : (seen_ce | lane_ce);
    end
  end
endmodule

// File: rtl/sdi_cadence_monitor.sv
`timescale 1ns/1ps
module sdi_cadence_monitor
  import sdi_interleaver_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       err_clr,
  input  logic       lane_ce,
  input  logic [2:0] pat_sel,
  input  logic       pat_chg,
  input  logic       hist_vld,
  input  logic       ce_prev,
  input  logic       seen_ce,
  input  logic [1:0] last_phase,
  output logic       cadence_err
);
  logic viol;

  always_comb begin
    viol = 1'b0;
    if (hist_vld && !pat_chg) begin
      case (pat_sel)
        PAT_PAIR_THRU, PAT_QUAD_FIX: viol = !lane_ce;
        PAT_PAIR_ALT,  PAT_QUAD_ALT: viol = (lane_ce == ce_prev);
        PAT_QUAD_ROT:
          viol = seen_ce && (lane_ce ? (last_phase != PH_LAST) : (last_phase == PH_LAST));
        default: viol = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          cadence_err <= 1'b0;
    else if (viol)    cadence_err <= 1'b1;
    else if (err_clr) cadence_err <= 1'b0;
  end
endmodule

// File: rtl/sdi_interleaver.sv
`timescale 1ns/1ps
module sdi_interleaver
  import sdi_interleaver_pkg::*;
#(
  parameter int LANE_W = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     lane_ce,
  input  logic [2:0]               pat_sel,
  input  logic [NUM_DS*LANE_W-1:0] ds_bus,
  input  logic                     err_clr,
  output logic [LANES*LANE_W-1:0]  tx_word,
  output logic                     cadence_err
);
  logic [1:0]              cur_phase, last_phase;
  logic                    pat_chg, hist_vld, ce_prev, seen_ce;
  logic [LANES*LANE_W-1:0] word_d;

  sdi_phase_tracker u_phase (
    .clk(clk), .rst(rst), .lane_ce(lane_ce), .pat_sel(pat_sel),
    .cur_phase(cur_phase), .last_phase(last_phase), .pat_chg(pat_chg),
    .hist_vld(hist_vld), .ce_prev(ce_prev), .seen_ce(seen_ce)
  );

  sdi_lane_mux #(.LANE_W(LANE_W)) u_mux (
    .pat_sel(pat_sel), .lane_ce(lane_ce), .phase(cur_phase),
    .ds_bus(ds_bus), .word(word_d)
  );

  sdi_cadence_monitor u_mon (
    .clk(clk), .rst(rst), .err_clr(err_clr), .lane_ce(lane_ce), .pat_sel(pat_sel),
    .pat_chg(pat_chg), .hist_vld(hist_vld), .ce_prev(ce_prev), .seen_ce(seen_ce),
    .last_phase(last_phase), .cadence_err(cadence_err)
  );

  always_ff @(posedge clk) begin
    if (rst) tx_word <= '0;
    else     tx_word <= word_d;
  end
endmodule

// File: rtl/sdi_interleaver_chk.sv
`timescale 1ns/1ps
module sdi_interleaver_chk
  import sdi_interleaver_pkg::*;
#(
  parameter int LANE_W = 10
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     lane_ce,
  input logic [2:0]               pat_sel,
  input logic [NUM_DS*LANE_W-1:0] ds_bus,
  input logic                     err_clr,
  input logic [LANES*LANE_W-1:0]  tx_word,
  input logic                     cadence_err
);
  localparam int HALF = 2 * LANE_W;

  function automatic logic [LANE_W-1:0] ds(input int n);
    return ds_bus[n*LANE_W-1 -: LANE_W];
  endfunction

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (tx_word == '0 && !cadence_err)); // R1

  AST_PAIR_LAYOUT: assert property (@(posedge clk) disable iff (rst)
    pat_sel == PAT_PAIR_THRU |=>
      tx_word == {{(LANES*LANE_W-HALF){1'b0}}, $past(ds(1)), $past(ds(2))}); // R2

  AST_FIX_LAYOUT: assert property (@(posedge clk) disable iff (rst)
    pat_sel == PAT_QUAD_FIX |=>
      tx_word == {$past(ds(1)), $past(ds(3)), $past(ds(2)), $past(ds(4))}); // R5

  AST_ROT_START: assert property (@(posedge clk) disable iff (rst)
    (pat_sel == PAT_QUAD_ROT && lane_ce) |=>
      tx_word == {$past(ds(4)), $past(ds(12)), $past(ds(8)), $past(ds(16))}); // R6

  AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (rst)
    pat_sel > PAT_QUAD_ROT |=> tx_word == '0); // R8

  AST_CE_DROP_FLAG: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && pat_sel == PAT_QUAD_FIX && $past(pat_sel) == PAT_QUAD_FIX && !lane_ce)
      |=> cadence_err); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (cadence_err && !err_clr) |=> cadence_err); // R12
endmodule

bind sdi_interleaver sdi_interleaver_chk #(.LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst(rst), .lane_ce(lane_ce), .pat_sel(pat_sel), .ds_bus(ds_bus),
  .err_clr(err_clr), .tx_word(tx_word), .cadence_err(cadence_err)
);

// File: tb/sdi_interleaver_bench.sv
`timescale 1ns/1ps
module sdi_interleaver_bench;
  localparam int W = 10;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           lane_ce = 1'b0;
  logic [2:0]     pat_sel = 3'd0;
  logic [16*W-1:0] ds_bus = '0;
  logic           err_clr = 1'b0;
  logic [4*W-1:0] tx_word;
  logic           cadence_err;

  sdi_interleaver #(.LANE_W(W)) u_sdi_interleaver (
    .clk(clk), .rst(rst), .lane_ce(lane_ce), .pat_sel(pat_sel), .ds_bus(ds_bus),
    .err_clr(err_clr), .tx_word(tx_word), .cadence_err(cadence_err)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural model state
  logic [4*W-1:0] exp_word = '0;
  bit    exp_err  = 0;
  string exp_tag  = "R1";
  int    m_pat    = 0;
  int    m_since  = 0;
  bit    m_seen   = 0;
  bit    m_prev   = 0;
  bit    m_hv     = 0;

  function automatic logic [W-1:0] dsv(input logic [16*W-1:0] b, input int n);
    return b[n*W-1 -: W];
  endfunction

  function automatic logic [4*W-1:0] arrange(input logic [16*W-1:0] b, input int p,
                                             input bit c, input int ph);
    int l[4];
    logic [4*W-1:0] r;
    l = '{0, 0, 0, 0};
    case (p)
      0: l = '{0, 0, 1, 2};
      1: l = c ? '{0, 0, 1, 3} : '{0, 0, 2, 4};
      2: l = c ? '{1, 5, 3, 7} : '{2, 6, 4, 8};
      3: l = '{1, 3, 2, 4};
      4: case (ph)
           0: l = '{4, 12, 8, 16};
           1: l = '{2, 10, 6, 14};
           2: l = '{3, 11, 7, 15};
           default: l = '{1, 9, 5, 13};
         endcase
      default: l = '{0, 0, 0, 0};
    endcase
    r = '0;
    for (int k = 0; k < 4; k++)
      if (l[k] != 0) r[(4-k)*W-1 -: W] = dsv(b, l[k]);
    return r;
  endfunction

  task automatic compare();
    checks++;
    if (tx_word !== exp_word) begin
      fails++;
      $display("FAIL %s word: actual=%h expected=%h", exp_tag, tx_word, exp_word);
    end
    checks++;
    if (cadence_err !== exp_err) begin
      fails++;
      $display("FAIL %s cadence_err: actual=%0b expected=%0b", exp_tag, cadence_err, exp_err);
    end
  endtask

  task automatic step(input int p, input bit c, input bit clr, input string tag);
    bit chg, viol;
    int d, ph;
    @(negedge clk);
    compare();
    ds_bus  = {$urandom, $urandom, $urandom, $urandom, $urandom};
    pat_sel = p[2:0];
    lane_ce = c;
    err_clr = clr;
    chg  = (p != m_pat);
    d    = m_since + 1;
    ph   = (c || chg) ? 0 : (d > 3 ? 3 : d);
    viol = 0;
    if (m_hv && !chg) begin
      case (p)
        0, 3: viol = !c;
        1, 2: viol = (c == m_prev);
        4:    if (m_seen) viol = c ? (d < 4) : (d >= 4);
        default: viol = 0;
      endcase
    end
    if (viol) exp_err = 1;
    else if (clr) exp_err = 0;
    exp_word = arrange(ds_bus, p, c, ph);
    exp_tag  = tag;
    m_since  = (c || chg) ? 0 : (d > 100 ? 100 : d);
    m_seen   = chg ? c : (m_seen | c);
    m_prev   = c;
    m_pat    = p;
    m_hv     = 1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; lane_ce = 1'b0; pat_sel = 3'd0; err_clr = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    exp_word = '0; exp_err = 0; exp_tag = "R1";
    m_pat = 0; m_since = 0; m_seen = 0; m_prev = 0; m_hv = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    do_reset();
    // R2 pass-through pair, R13 one-edge latency
    for (int i = 0; i < 6; i++) step(0, 1, 0, "R2");
    step(0, 1, 0, "R13");
    // R3 alternating pair
    for (int i = 0; i < 8; i++) step(1, (i % 2) == 0, 0, "R3");
    // R4 alternating quad
    for (int i = 0; i < 8; i++) step(2, (i % 2) == 0, 0, "R4");
    // R5 fixed quad
    for (int i = 0; i < 6; i++) step(3, 1, 0, "R5");
    // R6 four-phase rotation
    for (int i = 0; i < 16; i++) step(4, (i % 4) == 0, 0, "R6");
    // R7 saturation at last phase, R11 overlong gap
    step(4, 1, 0, "R7");
    for (int i = 0; i < 6; i++) step(4, 0, 0, "R7");
    step(4, 1, 1, "R11");
    step(4, 0, 1, "R12");
    for (int i = 0; i < 7; i++) step(4, (i % 4) == 3, 0, "R12");
    // R7 pattern change restarts phase
    step(4, 1, 0, "R7");
    step(4, 0, 0, "R7");
    step(2, 0, 0, "R7");
    step(4, 0, 0, "R7");
    step(4, 0, 0, "R7");
    step(4, 0, 1, "R7");
    // R8 undefined codes
    for (int p = 5; p < 8; p++) begin
      step(p, 1, 1, "R8");
      step(p, 0, 0, "R8");
    end
    // R9 enable dropped under continuous patterns
    step(0, 1, 1, "R9");
    step(0, 1, 1, "R9");
    step(0, 0, 0, "R9");
    step(0, 1, 0, "R9");
    step(3, 1, 1, "R9");
    step(3, 1, 1, "R9");
    step(3, 0, 0, "R9");
    step(3, 1, 1, "R9");
    // R10 repeated enable level under alternating patterns
    step(1, 1, 1, "R10");
    step(1, 0, 1, "R10");
    step(1, 0, 0, "R10");
    step(1, 1, 1, "R10");
    step(2, 1, 1, "R10");
    step(2, 1, 0, "R10");
    step(2, 0, 1, "R10");
    step(2, 1, 1, "R10");
    // R11 short gap under rotation
    step(4, 1, 1, "R11");
    step(4, 0, 1, "R11");
    step(4, 0, 1, "R11");
    step(4, 1, 0, "R11");
    // R12 clear coinciding with a violation: set wins
    step(4, 0, 1, "R12");
    step(4, 0, 1, "R12");
    step(4, 0, 1, "R12");
    step(4, 0, 1, "R12");
    step(4, 1, 1, "R12");
    step(4, 0, 1, "R12");
    step(0, 0, 1, "R12");
    step(0, 1, 0, "R12");
    @(negedge clk);
    compare();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R13 watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end
endmodule